// File: doc/BRIEF.md
# Staged-Operand ALU Datapath Slice

This block is the arithmetic slice of a processor built around one shared internal bus. Only one value can sit on that bus per cycle, so the first operand of a two-operand operation is parked in an operand register (Y) during one cycle. The second operand arrives on the bus in the next cycle. A two-way selector feeds the ALU's A input with either the parked operand or the constant 4, used for stepping an address. The B input is wired straight to the bus.

The ALU is purely combinational. It covers sixteen functions chosen by a 4-bit code. A result register (Z) captures the ALU output and four flags at the clock edge that ends the cycle in which the function is chosen. Z takes its data only from the ALU and never from the bus. Z drives the bus only when its output enable is asserted. The bus is modelled as a plain input (`bus_in`) plus a gated output (`bus_out`) with a separate enable (`bus_oe`), to be merged into the shared bus outside the block.

Top module: `opstage_datapath`

## Requirements
- R1: A synchronous active-high reset clears Y, Z and all four flags. After reset, `bus_out` is 0 whether or not the output enable is high.
- R2: At a rising edge with `y_load` high, Y takes `bus_in`. With `y_load` low, Y keeps its value.
- R3: ALU input A is the constant 4 when `sel_four` is high and Y otherwise. ALU input B is always `bus_in`.
- R4: The arithmetic codes are:
  - 0: A+B+carry_in
  - 1: A+B+1
  - 2: A-B
  - 3: A-B-1
  - 4: two's-complement negation of A (NOT A + 1)
  - 5: two's-complement negation of B (NOT B + 1)
- R5: `carry_in` adds only into code 0. Every other code gives the same result and flags whatever `carry_in` is.
- R6: The logic codes are:
  - 6: A AND B
  - 7: A OR B
  - 8: NOT A
  - 9: NOT B
  - 10: (NOT A) AND B
  - 11: A AND (NOT B)
  - 12: A XOR B
  - 13: NOT (A XOR B)
  - 14: pass A
  - 15: pass B
- R7: At a rising edge with `z_load` high, Z takes the ALU result. With `z_load` low, Z and the flags keep their values whatever the bus carries.
- R8: For codes 0 to 5, the carry flag is the carry out of the top bit. Subtraction is done as A + NOT B + 1, so for subtraction the carry flag means "no borrow". The overflow flag marks signed two's-complement overflow. Codes 6 to 15 clear both flags.
- R9: The zero flag is set when the captured result is all zeros. The negative flag equals the top bit of the captured result.
- R10: With `z_drive` high, `bus_out` equals Z and `bus_oe` is 1. With `z_drive` low, `bus_out` is 0 and `bus_oe` is 0.
- R11: When `y_load` and `z_load` are both high in the same cycle, Z is computed from the Y value held before that edge, and Y takes the new bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | W | Current value of the shared bus |
| y_load | input | 1 | Load Y from the bus at the next edge |
| sel_four | input | 1 | Select the constant 4 as ALU input A |
| func | input | 4 | ALU function code |
| carry_in | input | 1 | Carry into code 0 |
| z_load | input | 1 | Capture the ALU result and flags into Z |
| z_drive | input | 1 | Let Z drive the bus |
| bus_out | output | W | Z gated by the output enable |
| bus_oe | output | 1 | Output enable toward the bus |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero-result flag |
| flag_n | output | 1 | Negative-result flag |

## Verification
Each function code is driven through the full three-cycle sequence: stage Y, select the function, then read Z onto the bus. The operand pairs are small positives, operands that produce a borrow, values at the signed limit and all-zero/all-ones patterns. Together these separate the carry flag from the overflow flag, zero from negative, and the two subtraction variants from each other.

Running code 0 with both carry-in values, and the other codes with carry-in high, shows that only code 0 adds the carry. Selecting the constant 4 against a staged Y that differs from 4 shows which source the selector picked. Changing the bus while Z is not loaded shows that Z never takes bus data. Loading Y and Z in the same cycle shows that Z was computed from the old Y.

// File: rtl/opstage_pkg.sv
package opstage_pkg;

  typedef enum logic [3:0] {
    FN_ADD     = 4'd0,
    FN_ADD1    = 4'd1,
    FN_SUB     = 4'd2,
    FN_SUBDEC  = 4'd3,
    FN_NEGA    = 4'd4,
    FN_NEGB    = 4'd5,
    FN_AND     = 4'd6,
    FN_OR      = 4'd7,
    FN_NOTA    = 4'd8,
    FN_NOTB    = 4'd9,
    FN_NA_AND  = 4'd10,
    FN_AND_NB  = 4'd11,
    FN_XOR     = 4'd12,
    FN_XNOR    = 4'd13,
    FN_PASSA   = 4'd14,
    FN_PASSB   = 4'd15
  } alu_fn_e;

  localparam int unsigned FN_W = 4;

  function automatic logic fn_is_arith(input logic [FN_W-1:0] code);
    return code <= FN_NEGB;
  endfunction

endpackage

// File: rtl/opstage_yreg.sv
module opstage_yreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/opstage_amux.sv
module opstage_amux #(
  parameter int unsigned W = 16
) (
  input  logic         sel_four,
  input  logic [W-1:0] y_val,
  output logic [W-1:0] a_val
);

  localparam logic [W-1:0] FOUR = W'(4);

  // The selector must be able to hold the constant without truncation.
  if (W < 3) begin : g_bad_width
    initial $display("opstage_amux: width %0d cannot hold the constant 4", W);
  end

  assign a_val = sel_four ? FOUR : y_val;

endmodule

// File: rtl/opstage_alu.sv
module opstage_alu
  import opstage_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout,
  output logic            ovf
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] add_x, add_y;
  logic         add_k;
  logic [W:0]   add_sum;
  logic [W-1:0] logic_res;
  logic         arith;

  assign arith = fn_is_arith(fn);

  // Operand conditioning: every arithmetic code maps onto one adder.
  always_comb begin
    add_x = a;
    add_y = b;
    add_k = 1'b0;
    unique case (fn)
      FN_ADD:    begin add_x = a;  add_y = b;   add_k = cin;  end
      FN_ADD1:   begin add_x = a;  add_y = b;   add_k = 1'b1; end
      FN_SUB:    begin add_x = a;  add_y = ~b;  add_k = 1'b1; end
      FN_SUBDEC: begin add_x = a;  add_y = ~b;  add_k = 1'b0; end
      FN_NEGA:   begin add_x = ~a; add_y = '0;  add_k = 1'b1; end
      FN_NEGB:   begin add_x = ~b; add_y = '0;  add_k = 1'b1; end
      default:   begin add_x = a;  add_y = b;   add_k = 1'b0; end
    endcase
  end

  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_k};

  // Bitwise unit, one slice per bit.
  for (genvar i = 0; i < W; i++) begin : g_logic_bit
    always_comb begin
      unique case (fn)
        FN_AND:    logic_res[i] = a[i] & b[i];
        FN_OR:     logic_res[i] = a[i] | b[i];
        FN_NOTA:   logic_res[i] = ~a[i];
        FN_NOTB:   logic_res[i] = ~b[i];
        FN_NA_AND: logic_res[i] = ~a[i] & b[i];
        FN_AND_NB: logic_res[i] = a[i] & ~b[i];
        FN_XOR:    logic_res[i] = a[i] ^ b[i];
        FN_XNOR:   logic_res[i] = ~(a[i] ^ b[i]);
        FN_PASSA:  logic_res[i] = a[i];
        FN_PASSB:  logic_res[i] = b[i];
        default:   logic_res[i] = 1'b0;
      endcase
    end
  end

  assign res  = arith ? add_sum[W-1:0] : logic_res;
  assign cout = arith & add_sum[W];
  assign ovf  = arith & (add_x[MSB] == add_y[MSB]) & (add_sum[MSB] != add_x[MSB]);

endmodule

// File: rtl/opstage_zreg.sv
module opstage_zreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] res,
  input  logic         cout,
  input  logic         ovf,
  output logic [W-1:0] z_q,
  output logic         c_q,
  output logic         v_q,
  output logic         zf_q,
  output logic         nf_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q  <= '0;
      c_q  <= 1'b0;
      v_q  <= 1'b0;
      zf_q <= 1'b0;
      nf_q <= 1'b0;
    end else if (load) begin
      z_q  <= res;
      c_q  <= cout;
      v_q  <= ovf;
      zf_q <= (res == '0);
      nf_q <= res[W-1];
    end
  end

endmodule

// File: rtl/opstage_datapath.sv
module opstage_datapath
  import opstage_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    bus_in,
  input  logic            y_load,
  input  logic            sel_four,
  input  logic [FN_W-1:0] func,
  input  logic            carry_in,
  input  logic            z_load,
  input  logic            z_drive,
  output logic [W-1:0]    bus_out,
  output logic            bus_oe,
  output logic            flag_c,
  output logic            flag_v,
  output logic            flag_z,
  output logic            flag_n
);

  logic [W-1:0] y_q;
  logic [W-1:0] alu_a;
  logic [W-1:0] alu_res;
  logic         alu_c, alu_v;
  logic [W-1:0] z_q;

  opstage_yreg #(.W(W)) u_yreg (
    .clk (clk),
    .rst (rst),
    .load(y_load),
    .d   (bus_in),
    .q   (y_q)
  );

  opstage_amux #(.W(W)) u_amux (
    .sel_four(sel_four),
    .y_val   (y_q),
    .a_val   (alu_a)
  );

  opstage_alu #(.W(W)) u_alu (
    .a   (alu_a),
    .b   (bus_in),
    .fn  (func),
    .cin (carry_in),
    .res (alu_res),
    .cout(alu_c),
    .ovf (alu_v)
  );

  opstage_zreg #(.W(W)) u_zreg (
    .clk (clk),
    .rst (rst),
    .load(z_load),
    .res (alu_res),
    .cout(alu_c),
    .ovf (alu_v),
    .z_q (z_q),
    .c_q (flag_c),
    .v_q (flag_v),
    .zf_q(flag_z),
    .nf_q(flag_n)
  );

  assign bus_oe  = z_drive;
  assign bus_out = z_drive ? z_q : '0;

endmodule

// File: rtl/opstage_datapath_chk.sv
module opstage_datapath_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] bus_in,
  input logic         y_load,
  input logic         sel_four,
  input logic [3:0]   func,
  input logic         z_load,
  input logic [W-1:0] y_q,
  input logic [W-1:0] z_q,
  input logic [W-1:0] bus_out,
  input logic         bus_oe,
  input logic         flag_c,
  input logic         flag_v,
  input logic         flag_z,
  input logic         flag_n
);

  assert_y_capture_R2: assert property (@(posedge clk) disable iff (rst)
    y_load |=> (y_q == $past(bus_in)));

  assert_y_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !y_load |=> $stable(y_q));

  assert_four_select_R3: assert property (@(posedge clk) disable iff (rst)
    (z_load && sel_four && func == 4'd14) |=> (z_q == W'(4)));

  assert_logic_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (z_load && func >= 4'd6) |=> (!flag_c && !flag_v));

  assert_z_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !z_load |=> ($stable(z_q) && $stable(flag_c) && $stable(flag_v)
                 && $stable(flag_z) && $stable(flag_n)));

  assert_result_flags_R9: assert property (@(posedge clk) disable iff (rst)
    z_load |=> ((flag_z == (z_q == '0)) && (flag_n == z_q[W-1])));

  assert_bus_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_out == '0));

  assert_pass_y_R11: assert property (@(posedge clk) disable iff (rst)
    (z_load && !sel_four && func == 4'd14) |=> (z_q == $past(y_q)));

endmodule

bind opstage_datapath opstage_datapath_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_in  (bus_in),
  .y_load  (y_load),
  .sel_four(sel_four),
  .func    (func),
  .z_load  (z_load),
  .y_q     (y_q),
  .z_q     (z_q),
  .bus_out (bus_out),
  .bus_oe  (bus_oe),
  .flag_c  (flag_c),
  .flag_v  (flag_v),
  .flag_z  (flag_z),
  .flag_n  (flag_n)
);

// File: tb/opstage_datapath_tb.sv
`timescale 1ns/1ps
module opstage_datapath_tb_top;

  localparam int unsigned W = 16;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic         y_load = 1'b0;
  logic         sel_four = 1'b0;
  logic [3:0]   func = 4'd0;
  logic         carry_in = 1'b0;
  logic         z_load = 1'b0;
  logic         z_drive = 1'b0;
  logic [W-1:0] bus_out;
  logic         bus_oe;
  logic         flag_c, flag_v, flag_z, flag_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  opstage_datapath #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .y_load(y_load),
    .sel_four(sel_four), .func(func), .carry_in(carry_in),
    .z_load(z_load), .z_drive(z_drive), .bus_out(bus_out),
    .bus_oe(bus_oe), .flag_c(flag_c), .flag_v(flag_v),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model from the requirement text: returns {c, v, result}.
  function automatic logic [W+1:0] model(logic [3:0] f, logic [W-1:0] a,
                                         logic [W-1:0] b, logic ci);
    logic [W-1:0] r;
    logic c, v;
    longint sa, sb, sr;
    longint unsigned ua, ub, ur;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = 1'b0; v = 1'b0; r = '0;
    case (f)
      4'd0: begin ur = ua + ub + ci; sr = sa + sb + ci; end
      4'd1: begin ur = ua + ub + 1;  sr = sa + sb + 1;  end
      4'd2: begin ur = ua + (ub ^ 64'(ONES)) + 1; sr = sa - sb;     end
      4'd3: begin ur = ua + (ub ^ 64'(ONES));     sr = sa - sb - 1; end
      4'd4: begin ur = (ua ^ 64'(ONES)) + 1;      sr = -sa;         end
      4'd5: begin ur = (ub ^ 64'(ONES)) + 1;      sr = -sb;         end
      default: begin ur = 0; sr = 0; end
    endcase
    if (f <= 4'd5) begin
      r = ur[W-1:0];
      c = ur[W];
      v = (sr > longint'($signed(SMAX))) || (sr < longint'($signed(SMIN)));
    end else begin
      case (f)
        4'd6:  r = a & b;
        4'd7:  r = a | b;
        4'd8:  r = ~a;
        4'd9:  r = ~b;
        4'd10: r = ~a & b;
        4'd11: r = a & ~b;
        4'd12: r = a ^ b;
        4'd13: r = ~(a ^ b);
        4'd14: r = a;
        default: r = b;
      endcase
    end
    return {c, v, r};
  endfunction

  // Stage Y (optional), select the function, then read Z on the bus.
  task automatic run_op(string req, bit load_y, logic [W-1:0] yv, logic [W-1:0] bv,
                        logic [3:0] f, logic ci, logic s4, logic [W-1:0] a_exp);
    logic [W+1:0] e;
    if (load_y) begin
      @(negedge clk);
      z_drive = 0; bus_in = yv; y_load = 1; z_load = 0;
    end
    @(negedge clk);
    z_drive = 0; y_load = 0; bus_in = bv; func = f; carry_in = ci;
    sel_four = s4; z_load = 1;
    @(negedge clk);
    z_load = 0; sel_four = 0; bus_in = ~bv; z_drive = 1;
    #0.5;
    e = model(f, s4 ? W'(4) : a_exp, bv, ci);
    check_eq(req, $sformatf("result f=%0d", f), 64'(bus_out), 64'(e[W-1:0]));
    check_eq("R8", $sformatf("carry f=%0d", f), 64'(flag_c), 64'(e[W+1]));
    check_eq("R8", $sformatf("ovf f=%0d", f), 64'(flag_v), 64'(e[W]));
    check_eq("R9", "zero flag", 64'(flag_z), 64'(e[W-1:0] == '0));
    check_eq("R9", "neg flag", 64'(flag_n), 64'(e[W-1]));
  endtask

  task automatic t_reset();
    @(negedge clk); z_drive = 1; #0.5;
    check_eq("R1", "bus_out after reset", 64'(bus_out), 64'd0);
    check_eq("R1", "flags after reset", 64'({flag_c, flag_v, flag_z, flag_n}), 64'd0);
    // Y cleared: pass A without loading Y yields zero.
    run_op("R1", 0, '0, 16'h1234, 4'd14, 0, 0, '0);
  endtask

  task automatic t_arith();
    logic [W-1:0] av [6] = '{16'd5, 16'd3, SMAX, SMIN, 16'd0, ONES};
    logic [W-1:0] bv [6] = '{16'd3, 16'd5, 16'd1, 16'd1, 16'd0, 16'd1};
    for (int f = 0; f < 6; f++) begin
      for (int k = 0; k < 6; k++) begin
        run_op("R4", 1, av[k], bv[k], 4'(f), 0, 0, av[k]);
      end
    end
  endtask

  task automatic t_carry_in();
    run_op("R5", 1, 16'd10, 16'd20, 4'd0, 1, 0, 16'd10);
    run_op("R5", 1, ONES, 16'd0, 4'd0, 1, 0, ONES);
    for (int f = 1; f < 16; f++) begin
      run_op("R5", 1, 16'h00F0, 16'h0F3C, 4'(f), 1, 0, 16'h00F0);
    end
  endtask

  task automatic t_logic();
    for (int f = 6; f < 16; f++) begin
      run_op("R6", 1, 16'hF0A5, 16'h3C0F, 4'(f), 0, 0, 16'hF0A5);
      run_op("R6", 1, ONES, ONES, 4'(f), 0, 0, ONES);
    end
  endtask

  task automatic t_four();
    run_op("R3", 1, 16'h0100, 16'h0020, 4'd0, 0, 1, 16'h0100);
    run_op("R3", 1, 16'h0100, 16'h0000, 4'd14, 0, 1, 16'h0100);
    run_op("R3", 0, '0, 16'h0000, 4'd14, 0, 0, 16'h0100);
  endtask

  task automatic t_hold();
    run_op("R7", 1, 16'h00AA, 16'h0011, 4'd0, 0, 0, 16'h00AA);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      bus_in = 16'h7777 + 16'(i); func = 4'd15; z_load = 0; z_drive = 1;
    end
    #0.5;
    check_eq("R7", "Z held while bus changed", 64'(bus_out), 64'h00BB);
    check_eq("R7", "carry held", 64'(flag_c), 64'd0);
    run_op("R2", 0, '0, 16'h0000, 4'd14, 0, 0, 16'h00AA);
  endtask

  task automatic t_bus();
    run_op("R10", 1, 16'h8001, 16'h0000, 4'd14, 0, 0, 16'h8001);
    check_eq("R10", "oe high", 64'(bus_oe), 64'd1);
    @(negedge clk); z_drive = 0; #0.5;
    check_eq("R10", "bus_out idle", 64'(bus_out), 64'd0);
    check_eq("R10", "oe low", 64'(bus_oe), 64'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); z_drive = 0; bus_in = 16'h1111; y_load = 1;
    @(negedge clk); bus_in = 16'h2222; y_load = 1; z_load = 1; func = 4'd14; sel_four = 0;
    @(negedge clk); y_load = 0; z_load = 0; z_drive = 1; #0.5;
    check_eq("R11", "Z from old Y", 64'(bus_out), 64'h1111);
    run_op("R11", 0, '0, 16'h0000, 4'd14, 0, 0, 16'h2222);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_arith();
    t_carry_in();
    t_logic();
    t_four();
    t_hold();
    t_bus();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule